// File: doc/BRIEF.md
# Two-Wire Serial Clock Generator and Software Handshake Core

This block is the timing and control heart of a two-wire serial bus master. It derives the serial clock line from the system clock using an 8-bit divider register. It drives that line open-drain, so it can only pull the line low or let it float. A control register, reached over a small register bus, enables the interface and holds the start, stop and acknowledge requests. These requests are passed on as level outputs to the byte-level engine that sits beside this block.

Software and the bus meet at a completion flag. The byte engine pulses `job_done` when it finishes a bus job. The flag then sets, and the clock line is parked low at the end of its next low phase. The bus stays frozen until software writes a one to the flag bit. That write clears the flag, releases the line and emits a single-cycle `launch` pulse that tells the byte engine to start the next job. An interrupt request is raised while the flag, the local interrupt enable and the global interrupt enable are all set.

A write-collision bit records a data-register write made while the bus was running. The write is decoded here, and the data itself lives in the byte engine.

Top module: `i2c_scl_ctrl`

## Requirements
- R1: After synchronous reset, the rate register (address 0) and control register (address 1) read 0, `scl_drive_low`, `irq`, `launch`, `start_req`, `stop_req` and `ack_en` are all 0.
- R2: The rate register is 8-bit read/write at address 0. A read returns the value on `bus_rdata` one clock after the address is presented.
- R3: With the interface enabled and no flag set, `scl_drive_low` stays high for 8+rate clocks. It then stays low for 8+rate clocks when `scl_in` rises as soon as it is released, giving a period of 16+2×rate clocks.
- R4: The high phase lasts 8+rate clocks plus one clock for each rising clock edge at which `scl_in` is still sensed low after release. The block never pulls the line while waiting for it to rise.
- R5: While control bit 2 (enable) is 0, `scl_drive_low` is 0. After enable is written to 1, the line is pulled low starting the second clock, with a full 8+rate low phase.
- R6: Control register at address 1, with these bit positions. Bit 7 is the completion flag. Bit 6 is acknowledge enable. Bit 5 is the start request. Bit 4 is the stop request. Bit 3 is write collision and is read-only. Bit 2 is interface enable. Bit 1 always reads 0. Bit 0 is interrupt enable. Bits 6, 5, 4, 2 and 0 read back as written.
- R7: A `job_done` pulse sets the flag only while enable is 1, and it is ignored otherwise. When `job_done` and a clearing write happen in the same cycle, the flag stays set.
- R8: The flag is cleared only by a control write with bit 7 equal to 1. A control write with bit 7 equal to 0 leaves it unchanged.
- R9: While the flag is set, the line is held low once the low phase has run its count. It is released on the second clock after the clearing write.
- R10: `launch` is high for exactly one clock, in the cycle after a control write that actually clears a set flag.
- R11: `irq` equals flag AND interrupt enable AND `glb_irq_en`, registered, so it follows a change of `glb_irq_en` one clock later.
- R12: A write to address 2 sets control bit 3 when the flag is 0, and clears bit 3 when the flag is 1.
- R13: `ack_en`, `start_req` and `stop_req` follow control bits 6, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 rate, 1 control, 2 data |
| bus_we | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| job_done | input | 1 | Byte engine finished a job |
| glb_irq_en | input | 1 | Global interrupt enable |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_drive_low | output | 1 | Open-drain pull-down enable for the clock line |
| irq | output | 1 | Interrupt request |
| launch | output | 1 | One-cycle pulse: start next bus job |
| start_req | output | 1 | Start condition request to byte engine |
| stop_req | output | 1 | Stop condition request to byte engine |
| ack_en | output | 1 | Acknowledge enable to byte engine |

## Verification
A divider or phase counter that is off by one shows at once as a low or high phase one clock too long or too short. It is visible on `scl_drive_low` within a single clock period of 16+2×rate cycles. A flag stuck in the wrong state shows within one low phase, either as a line that never parks or as one that never resumes. It also shows one clock later on `irq` and on the control read-back. A wrong collision or launch decode shows on the next read of the control register, or in the very next cycle on `launch`.

// File: rtl/i2c_sclctl_pkg.sv
package i2c_sclctl_pkg;

  // register select codes on the bus
  localparam logic [1:0] SEL_RATE = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // control register bit positions
  localparam int CB_FLAG = 7;
  localparam int CB_ACK  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STO  = 4;
  localparam int CB_WCOL = 3;
  localparam int CB_EN   = 2;
  localparam int CB_IE   = 0;

  typedef enum logic [1:0] {
    SCL_IDLE = 2'd0,
    SCL_LOW  = 2'd1,
    SCL_RISE = 2'd2,
    SCL_HIGH = 2'd3
  } scl_state_t;

endpackage

// File: rtl/i2c_sclctl_regs.sv
module i2c_sclctl_regs
  import i2c_sclctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          job_done_i,
  input  logic          gie_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] rate_o,
  output logic          flag_o,
  output logic          en_o,
  output logic          irq_o,
  output logic          launch_o,
  output logic          sta_o,
  output logic          sto_o,
  output logic          ack_o
);

  logic [DW-1:0] rate_q;
  logic flag_q, ack_q, sta_q, sto_q, wcol_q, en_q, ie_q;
  logic flag_n, ack_n, sta_n, sto_n, wcol_n, en_n, ie_n;
  logic irq_q, launch_q;
  logic [DW-1:0] rdata_q, rd_mux;

  logic ctrl_wr, rate_wr, data_wr, clr_req;

  assign ctrl_wr = we_i && (addr_i == SEL_CTRL);
  assign rate_wr = we_i && (addr_i == SEL_RATE);
  assign data_wr = we_i && (addr_i == SEL_DATA);
  assign clr_req = ctrl_wr && wdata_i[CB_FLAG];

  always_comb begin
    flag_n = flag_q;
    if (clr_req)
      flag_n = 1'b0;
    if (job_done_i && en_q)
      flag_n = 1'b1;

    ack_n = ack_q;
    sta_n = sta_q;
    sto_n = sto_q;
    en_n  = en_q;
    ie_n  = ie_q;
    if (ctrl_wr) begin
      ack_n = wdata_i[CB_ACK];
      sta_n = wdata_i[CB_STA];
      sto_n = wdata_i[CB_STO];
      en_n  = wdata_i[CB_EN];
      ie_n  = wdata_i[CB_IE];
    end

    wcol_n = wcol_q;
    if (data_wr)
      wcol_n = !flag_q;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      SEL_RATE: rd_mux = rate_q;
      SEL_CTRL: begin
        rd_mux[CB_FLAG] = flag_q;
        rd_mux[CB_ACK]  = ack_q;
        rd_mux[CB_STA]  = sta_q;
        rd_mux[CB_STO]  = sto_q;
        rd_mux[CB_WCOL] = wcol_q;
        rd_mux[CB_EN]   = en_q;
        rd_mux[CB_IE]   = ie_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= '0;
      flag_q   <= 1'b0;
      ack_q    <= 1'b0;
      sta_q    <= 1'b0;
      sto_q    <= 1'b0;
      wcol_q   <= 1'b0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      irq_q    <= 1'b0;
      launch_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (rate_wr)
        rate_q <= wdata_i;
      flag_q   <= flag_n;
      ack_q    <= ack_n;
      sta_q    <= sta_n;
      sto_q    <= sto_n;
      wcol_q   <= wcol_n;
      en_q     <= en_n;
      ie_q     <= ie_n;
      irq_q    <= flag_n && ie_n && gie_i;
      launch_q <= flag_q && !flag_n;
      rdata_q  <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rate_o   = rate_q;
  assign flag_o   = flag_q;
  assign en_o     = en_q;
  assign irq_o    = irq_q;
  assign launch_o = launch_q;
  assign sta_o    = sta_q;
  assign sto_o    = sto_q;
  assign ack_o    = ack_q;

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(job_done_i && en_q));

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_req) |=> flag_q);

  // R10
  launch_once_chk: assert property (@(posedge clk) disable iff (rst)
    launch_q |=> !launch_q);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(gie_i) && flag_q && ie_q));

  // R12
  wcol_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol_q) |-> $past(data_wr && !flag_q));

endmodule

// File: rtl/i2c_sclctl_gen.sv
module i2c_sclctl_gen
  import i2c_sclctl_pkg::*;
#(
  parameter int DW          = 8,
  parameter int BASE_HALF   = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          hold_i,
  input  logic [DW-1:0] rate_i,
  input  logic          scl_i,
  output logic          drive_low_o
);

  localparam int CW = DW + 2;

  scl_state_t     st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [CW-1:0]  half, last;
  logic           scl_s;
  logic           drive_q;

  assign half = CW'(BASE_HALF) + CW'(rate_i);
  assign last = half - CW'(1);

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign scl_s = scl_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '1;
        end else begin
          sh[0] <= scl_i;
          for (int k = 1; k < SYNC_STAGES; k++)
            sh[k] <= sh[k-1];
        end
      end
      assign scl_s = sh[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!en_i) begin
      st_n  = SCL_IDLE;
      cnt_n = '0;
    end else begin
      case (st)
        SCL_IDLE: begin
          st_n  = SCL_LOW;
          cnt_n = '0;
        end
        SCL_LOW: begin
          if (cnt >= last) begin
            if (!hold_i) begin
              st_n  = SCL_RISE;
              cnt_n = '0;
            end
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        SCL_RISE: begin
          if (scl_s) begin
            st_n  = SCL_HIGH;
            cnt_n = CW'(1);
          end
        end
        SCL_HIGH: begin
          if (cnt >= last) begin
            st_n  = SCL_LOW;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        default: begin
          st_n  = SCL_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SCL_IDLE;
      cnt     <= '0;
      drive_q <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      drive_q <= (st_n == SCL_LOW);
    end
  end

  assign drive_low_o = drive_q;

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_q && hold_i && en_i) |=> drive_q);

  // R5
  off_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !drive_q);

  // R4
  rise_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SCL_RISE && !scl_s && en_i) |=> !drive_q);

endmodule

// File: rtl/i2c_scl_ctrl.sv
module i2c_scl_ctrl
  import i2c_sclctl_pkg::*;
#(
  parameter int DW          = 8,
  parameter int BASE_HALF   = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          job_done,
  input  logic          glb_irq_en,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          irq,
  output logic          launch,
  output logic          start_req,
  output logic          stop_req,
  output logic          ack_en
);

  logic [DW-1:0] rate;
  logic          flag;
  logic          en;

  i2c_sclctl_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .wdata_i    (bus_wdata),
    .job_done_i (job_done),
    .gie_i      (glb_irq_en),
    .rdata_o    (bus_rdata),
    .rate_o     (rate),
    .flag_o     (flag),
    .en_o       (en),
    .irq_o      (irq),
    .launch_o   (launch),
    .sta_o      (start_req),
    .sto_o      (stop_req),
    .ack_o      (ack_en)
  );

  i2c_sclctl_gen #(
    .DW          (DW),
    .BASE_HALF   (BASE_HALF),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_gen (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en),
    .hold_i      (flag),
    .rate_i      (rate),
    .scl_i       (scl_in),
    .drive_low_o (scl_drive_low)
  );

endmodule

// File: tb/i2c_scl_ctrl_test.sv
module i2c_scl_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       job_done = 1'b0;
  logic       glb_irq_en = 1'b0;
  logic       ext_hold = 1'b0;
  logic       scl_line;
  logic       scl_drive_low, irq, launch, start_req, stop_req, ack_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // open-drain line with instant pull-up; ext_hold models another device
  assign scl_line = ~scl_drive_low & ~ext_hold;

  i2c_scl_ctrl uut (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .job_done      (job_done),
    .glb_irq_en    (glb_irq_en),
    .scl_in        (scl_line),
    .scl_drive_low (scl_drive_low),
    .irq           (irq),
    .launch        (launch),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .ack_en        (ack_en)
  );

  // rate value and expected phase length (8 + rate)
  localparam int NVEC = 5;
  localparam int VEC [NVEC][2] = '{
    '{8, 16}, '{9, 17}, '{20, 28}, '{100, 108}, '{255, 263}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_job();
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
  endtask

  task automatic wait_oe(input logic v);
    while (scl_drive_low != v) @(negedge clk);
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (scl_drive_low == v) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lo, hi, run;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 scl_drive_low", scl_drive_low, 0);
    chk("R1 irq", irq, 0);
    chk("R1 launch", launch, 0);
    chk("R1 strobes", {start_req, stop_req, ack_en}, 0);
    bus_read(2'd0, rd); chk("R1 rate", rd, 0);
    bus_read(2'd1, rd); chk("R1 ctrl", rd, 0);

    // R2 rate read/write
    bus_write(2'd0, 8'hA5);
    bus_read(2'd0, rd); chk("R2 rate readback", rd, 8'hA5);

    // R6 R13 control layout, read-only bits
    bus_write(2'd1, 8'h7B);
    bus_read(2'd1, rd); chk("R6 ctrl readback", rd, 8'h71);
    chk("R13 ack_en", ack_en, 1);
    chk("R13 start_req", start_req, 1);
    chk("R13 stop_req", stop_req, 1);
    bus_write(2'd1, 8'h00);
    chk("R13 strobes cleared", {start_req, stop_req, ack_en}, 0);

    // R5 disabled: line never pulled; R7 job ignored
    run = 0;
    for (int i = 0; i < 100; i++) begin
      if (scl_drive_low) run++;
      @(negedge clk);
    end
    chk("R5 disabled pulls", run, 0);
    pulse_job();
    bus_read(2'd1, rd); chk("R7 job ignored while disabled", rd[7], 0);

    // R3 table walk
    bus_write(2'd1, 8'h04);
    for (int i = 0; i < NVEC; i++) begin
      bus_write(2'd0, 8'(VEC[i][0]));
      wait_oe(1'b1); wait_oe(1'b0); wait_oe(1'b1);
      run_len(1'b1, lo);
      run_len(1'b0, hi);
      chk($sformatf("R3 low rate=%0d", VEC[i][0]), lo, VEC[i][1]);
      chk($sformatf("R3 high rate=%0d", VEC[i][0]), hi, VEC[i][1]);
    end

    // R4 external stretch of the high phase
    bus_write(2'd0, 8'd8);
    wait_oe(1'b1); wait_oe(1'b0); wait_oe(1'b1);
    ext_hold = 1'b1;
    wait_oe(1'b0);
    hi = 0;
    while (!scl_drive_low) begin
      hi++;
      if (hi == 5) ext_hold = 1'b0;
      @(negedge clk);
    end
    chk("R4 stretched high", hi, 20);

    // R7 R11 flag set and interrupt
    bus_write(2'd1, 8'h05);
    glb_irq_en = 1'b1;
    pulse_job();
    chk("R11 irq on flag", irq, 1);
    bus_read(2'd1, rd); chk("R7 flag set", rd[7], 1);

    // R9 line parked low
    repeat (100) @(negedge clk);
    run = 0;
    for (int i = 0; i < 300; i++) begin
      if (!scl_drive_low) run++;
      @(negedge clk);
    end
    chk("R9 parked low", run, 0);

    // R8 writing 0 to flag bit
    bus_write(2'd1, 8'h05);
    bus_read(2'd1, rd); chk("R8 flag kept", rd[7], 1);

    // R11 global enable gating
    glb_irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irq off with gie 0", irq, 0);
    glb_irq_en = 1'b1;
    @(negedge clk);
    chk("R11 irq back with gie 1", irq, 1);

    // R7 R10 set wins over same-cycle clear
    bus_addr = 2'd1; bus_wdata = 8'h85; bus_we = 1'b1; job_done = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; job_done = 1'b0;
    chk("R10 no launch when set wins", launch, 0);
    bus_read(2'd1, rd); chk("R7 set wins", rd[7], 1);

    // R12 collision clear while flag set
    bus_write(2'd2, 8'h3C);
    bus_read(2'd1, rd); chk("R12 wcol clear with flag", rd[3], 0);

    // R9 R10 release
    bus_write(2'd1, 8'h85);
    chk("R10 launch pulse", launch, 1);
    chk("R9 still low in clear cycle", scl_drive_low, 1);
    chk("R11 irq dropped", irq, 0);
    @(negedge clk);
    chk("R10 launch one cycle", launch, 0);
    chk("R9 released", scl_drive_low, 0);

    // R12 collision set while flag clear
    bus_write(2'd2, 8'h11);
    bus_read(2'd1, rd); chk("R12 wcol set", rd[3], 1);

    // R5 disable then re-enable restarts with a full low phase
    bus_write(2'd1, 8'h00);
    @(negedge clk);
    chk("R5 released on disable", scl_drive_low, 0);
    bus_write(2'd1, 8'h04);
    chk("R5 not yet pulled", scl_drive_low, 0);
    @(negedge clk);
    run_len(1'b1, lo);
    chk("R5 first low phase", lo, 16);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule